// File: doc/BRIEF.md
# Shadow Stack Pointer Advance Unit

This block carries out the operation that moves a shadow stack pointer upward past a number of elements, in either a 4-byte or an 8-byte element form. A request brings a register operand, an element-size select, the current pointer, the privilege of the requester and one enable bit for each privilege class. When the shadow stack is off for the requester's class, the request ends at once with an invalid-opcode fault.

Otherwise the block checks the stack before it moves the pointer. It reads the first element that will be popped and then the last one, through a memory read port with a valid/ready request channel and a response channel that carries an error flag. Only after both reads succeed does it publish the advanced pointer and pulse done. A read error ends the request with a read fault and leaves the pointer alone. The block handles one request at a time and starts no new one until the current one is finished.

Top module: `ssp_advance_unit`

## Requirements
- R1: A request on `req_valid` in the idle state whose privilege class has its shadow stack disabled raises `ud_fault` for exactly one cycle, starting one clock after the request. It issues no read and leaves `new_ptr` unchanged.
- R2: The enable used is `ss_en_user` when `priv_user` is 1 and `ss_en_super` when `priv_user` is 0. The other enable bit has no effect.
- R3: The element count is bits [7:0] of `req_operand`. All higher operand bits are ignored.
- R4: The first read request goes out one clock after an accepted request. Its `rd_addr` equals the `cur_ptr` captured with the request, and `rd_wide` equals the captured `req_wide` (1 = 8-byte elements, 0 = 4-byte elements).
- R5: The second read is issued after the first response arrives without error. Its address is the captured pointer plus (E-1) times the element size, where E is the count, or 1 when the count is zero.
- R6: When the second response arrives without error, `done` pulses for one cycle starting on the next clock. `new_ptr` becomes the captured pointer plus the raw count times the element size. `new_ptr` is 0 after reset and changes only together with `done`.
- R7: A response with `rsp_err` = 1 to either read pulses `rd_fault` for one cycle instead of `done` and leaves `new_ptr` unchanged. An error on the first read means no second read is issued.
- R8: Reads are issued strictly in order, with at most one read outstanding. While `rd_valid` is high and `rd_ready` is low, `rd_addr` and `rd_wide` hold steady.
- R9: A `req_valid` that arrives while a request is in progress is ignored. So are changes to `cur_ptr` and the other request inputs after acceptance.
- R10: All address and pointer arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_operand | input | OW | Register operand; low 8 bits hold the count |
| req_wide | input | 1 | 1 = 8-byte elements, 0 = 4-byte elements |
| cur_ptr | input | AW | Current shadow stack pointer |
| priv_user | input | 1 | 1 = user privilege class, 0 = supervisor |
| ss_en_user | input | 1 | Shadow stack enable for the user class |
| ss_en_super | input | 1 | Shadow stack enable for the supervisor class |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rd_wide | output | 1 | Read size, 1 = 8 bytes |
| rsp_valid | input | 1 | Read response valid |
| rsp_err | input | 1 | Read response error |
| new_ptr | output | AW | Published shadow stack pointer |
| done | output | 1 | Successful completion pulse |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| rd_fault | output | 1 | Read error fault pulse |

## Verification
The bench targets a count of zero. A design that skipped the zero-to-one adjustment would send its second probe one element below the pointer, and a design that used the adjusted count for the final step would advance by one element. Operands with upper bits set catch a design that counts with the whole register. A count of 255 with 8-byte elements and a base near the top of the address space catch truncated shift logic and missing wraparound. Errors injected on each of the two reads, a stalled read channel with a stray request and a moving `cur_ptr` during the stall, and a disabled enable for each privilege class expose a design that leaks a second read, moves the pointer on failure, re-samples its inputs, or consults the wrong enable bit.

// File: rtl/ssp_adv_pkg.sv
package ssp_adv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ISSUE1 = 3'd1,
      ST_WAIT1  = 3'd2,
      ST_ISSUE2 = 3'd3,
      ST_WAIT2  = 3'd4
   } probe_st_t;

   localparam int unsigned NARROW_SHIFT = 2;
   localparam int unsigned WIDE_SHIFT   = 3;
endpackage

// File: rtl/ssp_req_gate.sv
module ssp_req_gate #(
   parameter int unsigned OW = 32,
   parameter int unsigned CW = 8
) (
   input  logic [OW-1:0] operand,
   input  logic          priv_user,
   input  logic          en_user,
   input  logic          en_super,
   output logic          allowed,
   output logic [CW-1:0] count
);
   // privilege class picks which enable applies
   assign allowed = priv_user ? en_user : en_super;

   generate
      if (OW > CW) begin : g_slice
         logic unused_hi;
         assign unused_hi = ^operand[OW-1:CW];
         assign count     = operand[CW-1:0];
      end else begin : g_full
         assign count = operand;
      end
   endgenerate
endmodule

// File: rtl/ssp_step_math.sv
module ssp_step_math #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   input  logic          wide,
   output logic [AW-1:0] last_addr,
   output logic [AW-1:0] final_ptr
);
   localparam int unsigned XW = CW + ssp_adv_pkg::WIDE_SHIFT;

   logic [CW-1:0] eff;
   logic [CW-1:0] last_idx;
   logic [XW-1:0] span_last;
   logic [XW-1:0] span_full;
   logic [AW-1:0] ext_last;
   logic [AW-1:0] ext_full;

   // zero count still probes the element at the base
   assign eff       = (count == '0) ? CW'(1) : count;
   assign last_idx  = eff - CW'(1);
   assign span_last = wide ? {last_idx, 3'b000} : {1'b0, last_idx, 2'b00};
   assign span_full = wide ? {count, 3'b000}    : {1'b0, count, 2'b00};

   generate
      if (AW > XW) begin : g_pad
         assign ext_last = {{(AW-XW){1'b0}}, span_last};
         assign ext_full = {{(AW-XW){1'b0}}, span_full};
      end else begin : g_trunc
         assign ext_last = span_last[AW-1:0];
         assign ext_full = span_full[AW-1:0];
      end
   endgenerate

   assign last_addr = base + ext_last;
   assign final_ptr = base + ext_full;
endmodule

// File: rtl/ssp_probe_ctrl.sv
module ssp_probe_ctrl
   import ssp_adv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic allowed,
   input  logic rd_ready,
   input  logic rsp_valid,
   input  logic rsp_err,
   output logic capture,
   output logic reject,
   output logic rd_valid,
   output logic second,
   output logic end_ok,
   output logic end_err
);
   probe_st_t st, st_nx;
   logic      idle;

   assign idle     = (st == ST_IDLE);
   assign capture  = idle & req_valid & allowed;
   assign reject   = idle & req_valid & ~allowed;
   assign rd_valid = (st == ST_ISSUE1) | (st == ST_ISSUE2);
   assign second   = (st == ST_ISSUE2);
   assign end_ok   = (st == ST_WAIT2) & rsp_valid & ~rsp_err;
   assign end_err  = ((st == ST_WAIT1) | (st == ST_WAIT2)) & rsp_valid & rsp_err;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (capture)   st_nx = ST_ISSUE1;
         ST_ISSUE1: if (rd_ready)  st_nx = ST_WAIT1;
         ST_WAIT1:  if (rsp_valid) st_nx = rsp_err ? ST_IDLE : ST_ISSUE2;
         ST_ISSUE2: if (rd_ready)  st_nx = ST_WAIT2;
         ST_WAIT2:  if (rsp_valid) st_nx = ST_IDLE;
         default:                  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end
endmodule

// File: rtl/ssp_advance_unit.sv
module ssp_advance_unit #(
   parameter int unsigned AW = 32,
   parameter int unsigned OW = 32,
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [OW-1:0] req_operand,
   input  logic          req_wide,
   input  logic [AW-1:0] cur_ptr,
   input  logic          priv_user,
   input  logic          ss_en_user,
   input  logic          ss_en_super,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [AW-1:0] rd_addr,
   output logic          rd_wide,
   input  logic          rsp_valid,
   input  logic          rsp_err,
   output logic [AW-1:0] new_ptr,
   output logic          done,
   output logic          ud_fault,
   output logic          rd_fault
);
   if (AW < 8)  begin : g_bad_aw $error("AW must be at least 8"); end
   if (CW < 1)  begin : g_bad_cw $error("CW must be at least 1"); end
   if (CW > OW) begin : g_bad_ow $error("CW must not exceed OW"); end

   logic          allowed, capture, reject, second, end_ok, end_err;
   logic [CW-1:0] count_in;
   logic [AW-1:0] base_q;
   logic [CW-1:0] cnt_q;
   logic          wide_q;
   logic [AW-1:0] last_addr, final_ptr;

   ssp_req_gate #(.OW(OW), .CW(CW)) u_gate (
      .operand  (req_operand),
      .priv_user(priv_user),
      .en_user  (ss_en_user),
      .en_super (ss_en_super),
      .allowed  (allowed),
      .count    (count_in)
   );

   ssp_probe_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .allowed  (allowed),
      .rd_ready (rd_ready),
      .rsp_valid(rsp_valid),
      .rsp_err  (rsp_err),
      .capture  (capture),
      .reject   (reject),
      .rd_valid (rd_valid),
      .second   (second),
      .end_ok   (end_ok),
      .end_err  (end_err)
   );

   ssp_step_math #(.AW(AW), .CW(CW)) u_math (
      .base     (base_q),
      .count    (cnt_q),
      .wide     (wide_q),
      .last_addr(last_addr),
      .final_ptr(final_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         wide_q <= 1'b0;
      end else if (capture) begin
         base_q <= cur_ptr;
         cnt_q  <= count_in;
         wide_q <= req_wide;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         new_ptr  <= '0;
         done     <= 1'b0;
         ud_fault <= 1'b0;
         rd_fault <= 1'b0;
      end else begin
         done     <= end_ok;
         ud_fault <= reject;
         rd_fault <= end_err;
         if (end_ok) new_ptr <= final_ptr;
      end
   end

   assign rd_addr = second ? last_addr : base_q;
   assign rd_wide = wide_q;
endmodule

// File: rtl/ssp_advance_chk.sv
module ssp_advance_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [AW-1:0] rd_addr,
   input logic          rd_wide,
   input logic          rsp_valid,
   input logic [AW-1:0] new_ptr,
   input logic          done,
   input logic          ud_fault,
   input logic          rd_fault
);
   logic [1:0] outstanding;

   always_ff @(posedge clk) begin
      if (!rst_n) outstanding <= '0;
      else if ((rd_valid && rd_ready) && !rsp_valid) outstanding <= outstanding + 2'd1;
      else if (!(rd_valid && rd_ready) && rsp_valid && outstanding != 0) outstanding <= outstanding - 2'd1;
   end

   p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (outstanding == 2'd0));

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_wide)));

   p_no_read_on_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault |-> (!rd_valid && outstanding == 2'd0));

   p_ptr_moves_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(new_ptr));

   p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, rd_fault, ud_fault}));

   p_fault_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fault |=> !rd_fault);
endmodule

bind ssp_advance_unit ssp_advance_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_valid (rd_valid),
   .rd_ready (rd_ready),
   .rd_addr  (rd_addr),
   .rd_wide  (rd_wide),
   .rsp_valid(rsp_valid),
   .new_ptr  (new_ptr),
   .done     (done),
   .ud_fault (ud_fault),
   .rd_fault (rd_fault)
);

// File: tb/ssp_advance_unit_test.sv
`timescale 1ns/1ps
module ssp_advance_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_operand = '0;
   logic        req_wide = 1'b0;
   logic [31:0] cur_ptr = '0;
   logic        priv_user = 1'b0;
   logic        ss_en_user = 1'b0;
   logic        ss_en_super = 1'b0;
   logic        rd_valid;
   logic        rd_ready = 1'b0;
   logic [31:0] rd_addr;
   logic        rd_wide;
   logic        rsp_valid = 1'b0;
   logic        rsp_err = 1'b0;
   logic [31:0] new_ptr;
   logic        done, ud_fault, rd_fault;

   int vectors = 0;
   int misses  = 0;

   // reference expectations, updated at falling edges
   logic        exp_rdv = 1'b0;
   logic [31:0] exp_addr = '0;
   logic        exp_wide = 1'b0;
   logic        exp_done = 1'b0;
   logic        exp_ud = 1'b0;
   logic        exp_rf = 1'b0;
   logic [31:0] exp_ptr = '0;
   string       tag = "R6 reset";
   bit          mon_on = 1'b0;

   always #4 clk = ~clk;

   ssp_advance_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_operand(req_operand),
      .req_wide(req_wide), .cur_ptr(cur_ptr), .priv_user(priv_user),
      .ss_en_user(ss_en_user), .ss_en_super(ss_en_super), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_wide(rd_wide),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .new_ptr(new_ptr),
      .done(done), .ud_fault(ud_fault), .rd_fault(rd_fault)
   );

   task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #3;
      if (mon_on) begin
         cmp("rd_valid", {31'b0, rd_valid}, {31'b0, exp_rdv});
         if (exp_rdv) begin
            cmp("rd_addr", rd_addr, exp_addr);
            cmp("rd_wide", {31'b0, rd_wide}, {31'b0, exp_wide});
         end
         cmp("done", {31'b0, done}, {31'b0, exp_done});
         cmp("ud_fault", {31'b0, ud_fault}, {31'b0, exp_ud});
         cmp("rd_fault", {31'b0, rd_fault}, {31'b0, exp_rf});
         cmp("new_ptr", new_ptr, exp_ptr);
      end
   end

   task automatic op(input logic [31:0] operand, input logic wide, input logic [31:0] base,
                     input logic user, input logic en_u, input logic en_s,
                     input logic err1, input logic err2, input logic stall, input string t);
      int          cnt;
      int          eff;
      int          sz;
      logic [31:0] a2, fin;
      cnt = int'(operand[7:0]);
      eff = (cnt == 0) ? 1 : cnt;
      sz  = wide ? 8 : 4;
      a2  = base + 32'(((eff - 1) * sz));
      fin = base + 32'((cnt * sz));
      @(negedge clk);
      tag = t;
      req_valid = 1'b1; req_operand = operand; req_wide = wide; cur_ptr = base;
      priv_user = user; ss_en_user = en_u; ss_en_super = en_s;
      if (!(user ? en_u : en_s)) begin
         exp_ud = 1'b1;
         @(negedge clk);
         req_valid = 1'b0; exp_ud = 1'b0;
         @(negedge clk);
         return;
      end
      exp_rdv = 1'b1; exp_addr = base; exp_wide = wide;
      @(negedge clk);
      req_valid = 1'b0; cur_ptr = ~base;
      if (stall) begin
         // stray request while busy, all enables off: must be ignored (R9)
         req_valid = 1'b1; req_operand = 32'h77; req_wide = ~wide;
         ss_en_user = 1'b0; ss_en_super = 1'b0;
         @(negedge clk);
         req_valid = 1'b0;
         @(negedge clk);
      end
      rd_ready = 1'b1; exp_rdv = 1'b0;
      @(negedge clk);
      rd_ready = 1'b0; rsp_valid = 1'b1; rsp_err = err1;
      if (err1) exp_rf = 1'b1;
      else begin exp_rdv = 1'b1; exp_addr = a2; end
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
      if (err1) begin
         exp_rf = 1'b0;
         @(negedge clk);
         return;
      end
      rd_ready = 1'b1; exp_rdv = 1'b0;
      @(negedge clk);
      rd_ready = 1'b0; rsp_valid = 1'b1; rsp_err = err2;
      if (err2) exp_rf = 1'b1;
      else begin exp_done = 1'b1; exp_ptr = fin; end
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0; exp_rf = 1'b0; exp_done = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;   // first compares check the reset state (R6)
      repeat (2) @(negedge clk);
      op(32'd3, 1'b0, 32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 R2 super disabled");
      op(32'd3, 1'b0, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 R2 user disabled");
      op(32'd5, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R5 R6 narrow count 5");
      op(32'd3, 1'b1, 32'h0000_4000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 R9 wide stalled");
      op(32'd0, 1'b0, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 zero count narrow");
      op(32'd0, 1'b1, 32'h0000_2100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 zero count wide");
      op(32'hABCD_0102, 1'b0, 32'h0000_3000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 upper operand bits");
      op(32'h0000_00FF, 1'b1, 32'h0001_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 count 255 wide");
      op(32'd4, 1'b1, 32'h0000_5000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 first read error");
      op(32'd4, 1'b0, 32'h0000_6000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 second read error");
      op(32'd8, 1'b1, 32'hFFFF_FFF0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 wraparound");
      op(32'd1, 1'b0, 32'h0000_7000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8 narrow stalled");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule